// File: doc/BRIEF.md
# Debounced Key Code Capture Register

This block sits between a 64-switch key array and a processor read bus. The switch lines come in as four groups of sixteen, and at most one line is normally high. All 64 lines pass through a shared stable-count filter. The filtered lines then go through two encoders. A 16-to-4 encoder gives the position of the line inside its group. A 4-to-3 encoder turns the group lines into a field whose top bit marks "some group is active". The two fields together form a 7-bit key code, so a code of zero always means that no key has been captured.

The code is latched at the moment the filtered array goes from "no key down" to "some key down". It stays in the latch until the next such moment. Software polls two addresses on a plain read bus. The status word at the base address plus 4 shows whether a fresh code is waiting and whether a code was replaced before it was read. Reading the data word at the base address returns the code and marks it as consumed.

Top module: `keycap_top`

## Requirements
- R1: After reset the status word reads 0 and the data word reads 0.
- R2: Key line k (group g = k / 16, line l = k mod 16) is captured as the code {1'b1, g[1:0], l[3:0]}, which equals 64 + k. The data word carries this code in bits 6:0, and bits 31:7 read 0.
- R3: When several filtered lines are high at the moment of capture, the lowest-numbered group wins, and inside that group the lowest-numbered line wins.
- R4: A change on the key lines that lasts STABLE_CYCLES clock cycles or fewer is never captured. A change held for 2*STABLE_CYCLES+1 cycles or more is captured.
- R5: A capture happens only when the filtered array goes from all-released to at least one line high. Changing which key is held while some key stays down does not replace the latched code and does not set the waiting flag.
- R6: The latched code does not change when the key is released or when the code is read. It changes only at the next capture.
- R7: Bit 0 of the status word (address base+4) is set by a capture. A read of the data word (address base) clears it, unless a capture happens in the same cycle.
- R8: A capture while status bit 0 is set, with no data read in that cycle, sets status bit 1. Bit 1 stays set until the status word is read, and that read clears bit 1 but leaves bit 0 unchanged.
- R9: With the read enable low, or at any other address, the bus returns 0 and the status bits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyLines | input | 64 | Raw switch lines, index = 16*group + line |
| rdEn | input | 1 | Read enable for the read bus |
| rdAddr | input | 8 | Byte address of the read |
| rdData | output | 32 | Read data, combinational from rdEn and rdAddr |

## Verification
The checker watches, on every cycle, the things that can be judged from local state. A waiting code always carries its marker bit. The latch holds its value except on a capture strobe. A capture happens only on a rise of the filtered any-key signal. The data read clears the waiting flag, the overrun bit survives until a status read, and the bus is quiet when it is not enabled. Only the bench scenarios can show the remaining behaviour: the arithmetic mapping from each of the 64 lines to its code, the priority among lines pressed together, the rejection of short glitches, the absence of a capture when the held key changes, and the exact status sequence around an overrun.

// File: rtl/keycap_pkg.sv
package keycap_pkg;
  // strobes issued by the control to the datapath
  typedef struct packed {
    logic latchCode;
  } keycap_ctl_t;
endpackage

// File: rtl/keycap_datapath.sv
module keycap_datapath
  import keycap_pkg::*;
#(
  parameter int GROUPS        = 4,
  parameter int LINES         = 16,
  parameter int STABLE_CYCLES = 4
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic [GROUPS*LINES-1:0]                     keyLines,
  input  keycap_ctl_t                                 ctl,
  output logic                                        anyKey,
  output logic [$clog2(GROUPS)+$clog2(LINES):0]       keyCode
);
  localparam int KEYS   = GROUPS * LINES;
  localparam int GSEL_W = $clog2(GROUPS);
  localparam int LINE_W = $clog2(LINES);
  localparam int CODE_W = GSEL_W + 1 + LINE_W;
  localparam int CNT_W  = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STABLE_CYCLES - 1);

  logic [KEYS-1:0]   sampleQ;
  logic [KEYS-1:0]   stableQ;
  logic [CNT_W-1:0]  holdCnt;

  // stable-count filter shared by all lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleQ <= '0;
      stableQ <= '0;
      holdCnt <= '0;
    end else begin
      sampleQ <= keyLines;
      if (keyLines != sampleQ) begin
        holdCnt <= '0;
      end else if (holdCnt != CNT_TOP) begin
        holdCnt <= holdCnt + 1'b1;
      end else begin
        stableQ <= sampleQ;
      end
    end
  end

  // per-group activity
  logic [GROUPS-1:0] groupHit;
  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    assign groupHit[g] = |stableQ[g*LINES +: LINES];
  end

  // group encoder: lowest active group wins, top bit marks activity
  logic [GSEL_W-1:0] grpSel;
  always_comb begin
    grpSel = '0;
    for (int g = GROUPS - 1; g >= 0; g--) begin
      if (groupHit[g]) grpSel = GSEL_W'(g);
    end
  end

  // line encoder inside the selected group: lowest active line wins
  logic [LINES-1:0]  groupLines;
  logic [LINE_W-1:0] lineSel;
  assign groupLines = stableQ[grpSel*LINES +: LINES];
  always_comb begin
    lineSel = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (groupLines[i]) lineSel = LINE_W'(i);
    end
  end

  assign anyKey = |groupHit;

  logic [CODE_W-1:0] codeQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '0;
    end else if (ctl.latchCode) begin
      codeQ <= {anyKey, grpSel, lineSel};
    end
  end

  assign keyCode = codeQ;
endmodule

// File: rtl/keycap_control.sv
module keycap_control
  import keycap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyKey,
  input  logic        dataRd,
  input  logic        statRd,
  output keycap_ctl_t ctl,
  output logic        valid,
  output logic        overrun
);
  logic anyPrev;
  logic capture;

  assign capture       = anyKey & ~anyPrev;
  assign ctl.latchCode = capture;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anyPrev <= 1'b0;
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      anyPrev <= anyKey;
      if (capture) begin
        valid <= 1'b1;
      end else if (dataRd) begin
        valid <= 1'b0;
      end
      if (capture && valid && !dataRd) begin
        overrun <= 1'b1;
      end else if (statRd) begin
        overrun <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/keycap_top.sv
module keycap_top
  import keycap_pkg::*;
#(
  parameter int                GROUPS        = 4,
  parameter int                LINES         = 16,
  parameter int                STABLE_CYCLES = 4,
  parameter int                ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR     = 8'h40
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [GROUPS*LINES-1:0]  keyLines,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [31:0]              rdData
);
  localparam int CODE_W = $clog2(GROUPS) + 1 + $clog2(LINES);
  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(4);

  keycap_ctl_t       ctlStrobes;
  logic              anyKey;
  logic [CODE_W-1:0] keyCode;
  logic              valid;
  logic              overrun;
  logic              dataRd;
  logic              statRd;
  logic              captureStb;

  assign dataRd     = rdEn && (rdAddr == BASE_ADDR);
  assign statRd     = rdEn && (rdAddr == STAT_ADDR);
  assign captureStb = ctlStrobes.latchCode;

  keycap_datapath #(
    .GROUPS(GROUPS), .LINES(LINES), .STABLE_CYCLES(STABLE_CYCLES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .keyLines(keyLines), .ctl(ctlStrobes),
    .anyKey(anyKey), .keyCode(keyCode)
  );

  keycap_control i_control (
    .clk(clk), .rstN(rstN), .anyKey(anyKey), .dataRd(dataRd),
    .statRd(statRd), .ctl(ctlStrobes), .valid(valid), .overrun(overrun)
  );

  always_comb begin
    rdData = '0;
    if (dataRd) begin
      rdData[CODE_W-1:0] = keyCode;
    end else if (statRd) begin
      rdData[1:0] = {overrun, valid};
    end
  end
endmodule

// File: rtl/keycap_checker.sv
module keycap_checker #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
  parameter int                CODE_W    = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [31:0]       rdData,
  input logic              anyKey,
  input logic              captureStb,
  input logic              valid,
  input logic              overrun,
  input logic [CODE_W-1:0] keyCode
);
  logic chkDataRd;
  logic chkStatRd;
  assign chkDataRd = rdEn && (rdAddr == BASE_ADDR);
  assign chkStatRd = rdEn && (rdAddr == BASE_ADDR + ADDR_W'(4));

  AST_CODE_MARKED: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> keyCode[CODE_W-1]); // R2

  AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    captureStb |-> (anyKey && !$past(anyKey))); // R5

  AST_CAPTURE_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    captureStb |=> valid); // R7

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !captureStb |=> $stable(keyCode)); // R6

  AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (chkDataRd && !captureStb) |=> !valid); // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !chkStatRd) |=> overrun); // R8

  AST_STATUS_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (chkStatRd && valid) |=> valid); // R8

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == 32'd0)); // R9
endmodule

bind keycap_top keycap_checker #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CODE_W(CODE_W)
) i_checker (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .anyKey(anyKey), .captureStb(captureStb), .valid(valid),
  .overrun(overrun), .keyCode(keyCode)
);

// File: tb/test_keycap_top.sv
`timescale 1ns/1ps
module test_keycap_top;
  localparam int N    = 4;
  localparam int HOLD = 3 * N;
  localparam logic [7:0] BASE = 8'h40;
  localparam logic [7:0] STAT = 8'h44;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] keyLines = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keycap_top #(.STABLE_CYCLES(N), .BASE_ADDR(BASE)) i_keycap_top (
    .clk(clk), .rstN(rstN), .keyLines(keyLines), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busRead(input logic [7:0] addr, output logic [31:0] val);
    @(negedge clk);
    rdEn = 1'b1;
    rdAddr = addr;
    #1 val = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setLines(input logic [63:0] v);
    @(negedge clk);
    keyLines = v;
    idle(HOLD);
  endtask

  task automatic expectRead(input string tag, input logic [7:0] addr, input logic [31:0] exp);
    logic [31:0] v;
    busRead(addr, v);
    check(tag, v, exp);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    expectRead("R1 status after reset", STAT, 32'd0);
    expectRead("R1 data after reset", BASE, 32'd0);

    // R2 every line maps to 64+k
    for (int k = 0; k < 64; k++) begin
      setLines(64'd1 << k);
      setLines(64'd0);
      expectRead("R7 status set by capture", STAT, 32'd1);
      expectRead("R2 code of line", BASE, 32'(64 + k));
      expectRead("R7 status cleared by data read", STAT, 32'd0);
    end

    // R6 code held after release and after reads
    expectRead("R6 code held", BASE, 32'd127);
    expectRead("R6 no new flag", STAT, 32'd0);

    // R3 priority among simultaneous lines
    setLines((64'd1 << 5) | (64'd1 << 40));
    setLines(64'd0);
    expectRead("R3 lower group wins", BASE, 32'(64 + 5));
    setLines((64'd1 << 17) | (64'd1 << 18));
    setLines(64'd0);
    expectRead("R3 lower line wins", BASE, 32'(64 + 17));
    setLines((64'd1 << 33) | (64'd1 << 63));
    setLines(64'd0);
    expectRead("R3 group two over three", BASE, 32'(64 + 33));

    // R4 short glitch is ignored, long hold is taken
    @(negedge clk);
    keyLines = 64'd1 << 9;
    idle(N);
    keyLines = 64'd0;
    idle(HOLD);
    expectRead("R4 glitch not captured", STAT, 32'd0);
    expectRead("R4 glitch leaves code", BASE, 32'(64 + 33));
    setLines(64'd1 << 9);
    setLines(64'd0);
    expectRead("R4 long hold captured", STAT, 32'd1);
    expectRead("R4 long hold code", BASE, 32'(64 + 9));

    // R5 changing held key without release
    setLines(64'd1 << 3);
    expectRead("R5 first key code", BASE, 32'(64 + 3));
    setLines((64'd1 << 3) | (64'd1 << 50));
    setLines(64'd1 << 50);
    expectRead("R5 no capture while held", STAT, 32'd0);
    expectRead("R5 code unchanged", BASE, 32'(64 + 3));
    setLines(64'd0);

    // R8 overrun
    setLines(64'd1 << 10);
    setLines(64'd0);
    setLines(64'd1 << 20);
    setLines(64'd0);
    expectRead("R8 overrun and valid", STAT, 32'd3);
    expectRead("R8 status read clears only overrun", STAT, 32'd1);
    expectRead("R8 newest code kept", BASE, 32'(64 + 20));
    expectRead("R8 all clear", STAT, 32'd0);

    // R9 foreign address and disabled reads
    setLines(64'd1 << 7);
    setLines(64'd0);
    expectRead("R9 other address reads zero", 8'h48, 32'd0);
    @(negedge clk);
    rdAddr = BASE;
    rdEn = 1'b0;
    #1 check("R9 disabled read is zero", rdData, 32'd0);
    idle(2);
    expectRead("R9 status untouched", STAT, 32'd1);
    expectRead("R9 code untouched", BASE, 32'(64 + 7));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule